// File: doc/BRIEF.md
# Single-Clock Fall-Through Word Queue

This block is a first-in, first-out word buffer that runs in one clock domain. A producer offers words with a push strobe and watches the full flag. A consumer sees the oldest stored word on the output as soon as it is stored, with no read strobe needed, and uses a pop strobe to discard that word and move on. A registered fill level reports how many words are held. The empty and full flags are derived from that level.

Word width and depth are parameters, and the depth must be a power of two. The read and write pointers are each log2(depth) bits wide and wrap on their own. The level is one bit wider, so that it can hold the full depth. A push and a pop may arrive in the same cycle at any fill level. At full, both are taken. At empty, the push is taken and the pop is ignored, because there is no word to pop. An extra check that the pointer difference agrees with the level is built in only when the FORMAL macro is defined.

Top module: `fwft_queue`

## Requirements
- R1: A synchronous active-low reset (rst_n = 0 at a rising edge) empties the queue, giving level_o = 0, empty_o = 1 and full_o = 0 after that edge.
- R2: While empty_o = 0, pop_data_o already holds the oldest stored word, and it stays unchanged over any cycle without a pop.
- R3: empty_o = 1 exactly when level_o = 0, and full_o = 1 exactly when level_o = DEPTH.
- R4: level_o never exceeds DEPTH and changes by at most one per cycle. It equals the number of words accepted minus the number removed.
- R5: A push while full_o = 1 with no pop in the same cycle is ignored. Level and head word stay unchanged.
- R6: A pop while empty_o = 1 with no push in the same cycle is ignored. The level stays 0 and the next pushed word becomes the head.
- R7: A push and a pop in the same cycle while the queue is not empty are both accepted, including at full. The level is unchanged.
- R8: A push and a pop in the same cycle while the queue is empty accept only the push. The level becomes 1 and the pushed word is the head.
- R9: Every accepted word is presented on pop_data_o unmodified and in the order it was pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Request to store push_data_i |
| push_data_i | input | WIDTH | Word to store |
| full_o | output | 1 | Queue holds DEPTH words |
| pop_i | input | 1 | Request to remove the head word |
| pop_data_o | output | WIDTH | Oldest stored word (valid while empty_o = 0) |
| empty_o | output | 1 | Queue holds no words |
| level_o | output | $clog2(DEPTH)+1 | Registered number of stored words |

## Verification
The write path and the read path can both act in the same cycle. That case is driven at three fill levels: an interior level, full, and empty. At an interior level or at full, the bench expects the level to hold and the head to move to the next word. A reference queue in the bench decides which word that is. At empty, the bench expects only the push to take effect, leaving a level of 1 with the pushed word visible at once. The checker also asserts that a pushed word never disturbs a visible head unless a pop is made.

// File: rtl/fwft_pkg.sv
// Package: shared types for the fall-through queue.
// Assumes: nothing beyond IEEE 1800-2017.
package fwft_pkg;

    // What the queue does to its fill level in one cycle, after admission.
    typedef enum logic [1:0] {
        LVL_HOLD = 2'b00,
        LVL_INC  = 2'b01,
        LVL_DEC  = 2'b10,
        LVL_SWAP = 2'b11
    } lvl_op_e;

endpackage

// File: rtl/fwft_wrap_ptr.sv
// Module: wrapping address pointer.
// Moves forward by one slot on each cycle that adv is high and wraps
// naturally at 2**AW. Assumes the depth is a power of two, so the wrap is free.
module fwft_wrap_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    // Purpose: clear on reset, otherwise step by one slot on an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + AW'(1);
        end
    end

endmodule

// File: rtl/fwft_level.sv
// Module: fill-level register and flag decode.
// Holds the registered word count and derives empty and full from it.
// Assumes the caller never requests LVL_INC at full or LVL_DEC at empty.
module fwft_level
    import fwft_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  lvl_op_e     op,
    output logic [AW:0] level,
    output logic        empty,
    output logic        full
);

    localparam logic [AW:0] LVL_MAX = (AW+1)'(2 ** AW);

    logic [AW:0] level_q;

    // Purpose: apply the admitted push/pop effect to the stored level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            unique case (op)
                LVL_INC:  level_q <= level_q + (AW+1)'(1);
                LVL_DEC:  level_q <= level_q - (AW+1)'(1);
                default:  level_q <= level_q;
            endcase
        end
    end

    // Purpose: decode the flags from the registered level only.
    always_comb begin
        level = level_q;
        empty = (level_q == '0);
        full  = (level_q == LVL_MAX);
    end

endmodule

// File: rtl/fwft_store.sv
// Module: word storage with one write port and one asynchronous read port.
// Writes land on the rising edge. The read is combinational, so the head
// word is visible without a strobe. Storage is not reset.
module fwft_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Purpose: store an admitted word in its slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Purpose: present the slot under the read pointer (fall-through view).
    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/fwft_queue.sv
// Module: top of the single-clock fall-through queue.
// Decides which push and pop requests are admitted, steps the two pointers
// and the level, and wires the storage. Assumes DEPTH is a power of two
// and at least 2. A pop at empty is never admitted. A push at full is
// admitted only together with a pop.
module fwft_queue
    import fwft_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [WIDTH-1:0]         push_data_i,
    output logic                     full_o,
    input  logic                     pop_i,
    output logic [WIDTH-1:0]         pop_data_o,
    output logic                     empty_o,
    output logic [$clog2(DEPTH):0]   level_o
);

    localparam int AW = $clog2(DEPTH);

    logic          push_ok;
    logic          pop_ok;
    lvl_op_e       op;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   level;
    logic          empty;
    logic          full;

    // Purpose: admit requests; a pop frees the slot a push at full needs.
    always_comb begin
        pop_ok  = pop_i && !empty;
        push_ok = push_i && (!full || pop_ok);
        op      = lvl_op_e'({pop_ok, push_ok});
        if (op == LVL_SWAP) begin
            op = LVL_HOLD;
        end
    end

    fwft_wrap_ptr #(.AW(AW)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (push_ok),
        .ptr   (wr_ptr)
    );

    fwft_wrap_ptr #(.AW(AW)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pop_ok),
        .ptr   (rd_ptr)
    );

    fwft_level #(.AW(AW)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .level (level),
        .empty (empty),
        .full  (full)
    );

    fwft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (push_data_i),
        .raddr (rd_ptr),
        .rdata (pop_data_o)
    );

    // Purpose: drive the status outputs.
    always_comb begin
        full_o  = full;
        empty_o = empty;
        level_o = level;
    end

`ifdef FORMAL
    // Purpose: internal invariant (R4): the pointer distance matches the level.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_ptr_agree: assert ((wr_ptr - rd_ptr) == level[AW-1:0]);
        end
    end
`endif

endmodule

// File: rtl/fwft_queue_chk.sv
// Module: port-level property checker for fwft_queue, attached by bind.
// Observes ports only and drives nothing.
module fwft_queue_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   push_i,
    input logic                   pop_i,
    input logic                   full_o,
    input logic                   empty_o,
    input logic [WIDTH-1:0]       pop_data_o,
    input logic [$clog2(DEPTH):0] level_o
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0 && empty_o && !full_o));

    a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_o && !pop_i) |=> $stable(pop_data_o));

    a_r3_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o == (level_o == '0)) && (full_o == (level_o == LVL_MAX)));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_MAX);

    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level_o == $past(level_o) ||
                  level_o == $past(level_o) + 1'b1 ||
                  level_o == $past(level_o) - 1'b1));

    a_r5_full_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (full_o && $stable(pop_data_o)));

    a_r6_empty_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> empty_o);

    a_r7_both_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_o && push_i && pop_i) |=> $stable(level_o));

    a_r8_both_at_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && push_i && pop_i) |=> (level_o == (AW+1)'(1)));

endmodule

bind fwft_queue fwft_queue_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .pop_data_o (pop_data_o),
    .level_o    (level_o)
);

// File: tb/fwft_queue_tb_top.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed corner tests.
// A reference queue in the bench supplies the expected head words.
module fwft_queue_tb_top;

    localparam int W  = 8;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [W-1:0]  din = '0;
    logic          full;
    logic          empty;
    logic [W-1:0]  head;
    logic [AW:0]   level;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] model [$];

    always #2.5 clk = ~clk;

    fwft_queue #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (din),
        .full_o      (full),
        .pop_i       (pop),
        .pop_data_o  (head),
        .empty_o     (empty),
        .level_o     (level)
    );

    // Table entry: push, pop, data[7:0], expected level[4:0], expected head[7:0].
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'hA1, 5'd1, 8'hA1},
        {1'b1, 1'b0, 8'hB2, 5'd2, 8'hA1},
        {1'b0, 1'b1, 8'h00, 5'd1, 8'hB2},
        {1'b1, 1'b1, 8'hC3, 5'd1, 8'hC3},
        {1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
        {1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
        {1'b1, 1'b1, 8'hD4, 5'd1, 8'hD4},
        {1'b1, 1'b0, 8'hE5, 5'd2, 8'hD4},
        {1'b0, 1'b0, 8'h00, 5'd2, 8'hD4},
        {1'b0, 1'b1, 8'h00, 5'd1, 8'hE5},
        {1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
        {1'b1, 1'b0, 8'hF6, 5'd1, 8'hF6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Apply one cycle of requests (called at a negedge), update the model, return at the next negedge.
    task automatic step(input logic p, input logic q, input logic [W-1:0] d);
        logic pop_ok;
        logic push_ok;
        push = p; pop = q; din = d;
        pop_ok  = q && (model.size() > 0);
        push_ok = p && ((model.size() < D) || pop_ok);
        @(posedge clk);
        if (pop_ok)  void'(model.pop_front());
        if (push_ok) model.push_back(d);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
    endtask

    // Compare the ports with the reference queue.
    task automatic verify(input string req);
        check({req, " level"}, 32'(level), 32'(model.size()));
        check("R3 empty flag", 32'(empty), 32'(model.size() == 0));
        check("R3 full flag", 32'(full), 32'(model.size() == D));
        if (model.size() > 0) check({req, " R9 head"}, 32'(head), 32'(model[0]));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : main
        logic [W-1:0] held;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 level", 32'(level), 0);
        check("R1 empty", 32'(empty), 1);
        check("R1 full", 32'(full), 0);
        rst_n = 1'b1;

        // Table walk: R2 fall-through, R6/R7/R8 simultaneous and blocked cases
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][22], VEC[i][21], VEC[i][20:13]);
            check("R4 table level", 32'(level), 32'(VEC[i][12:8]));
            if (VEC[i][12:8] != 0) check("R2 table head", 32'(head), 32'(VEC[i][7:0]));
            else check("R6 table empty", 32'(empty), 1);
        end

        // Drain, then fill to full: R3, R4
        step(1'b0, 1'b1, '0);
        verify("R4");
        for (int i = 0; i < D; i++) begin
            step(1'b1, 1'b0, W'(i * 7 + 3));
            verify("R4");
        end
        check("R3 full at DEPTH", 32'(full), 1);

        // R5: push at full without pop is ignored
        held = head;
        step(1'b1, 1'b0, 8'hEE);
        check("R5 level", 32'(level), D);
        check("R5 head", 32'(head), 32'(held));

        // R7: push and pop together at full
        step(1'b1, 1'b1, 8'h55);
        check("R7 level at full", 32'(level), D);
        verify("R7");

        // R9: drain everything and compare order
        for (int i = 0; i < D; i++) begin
            verify("R9");
            step(1'b0, 1'b1, '0);
        end
        check("R9 empty after drain", 32'(empty), 1);

        // R6: pop at empty ignored, next push becomes head
        step(1'b0, 1'b1, '0);
        check("R6 level", 32'(level), 0);
        step(1'b1, 1'b0, 8'h3C);
        check("R6 head", 32'(head), 32'h3C);

        // R8: push and pop at empty
        step(1'b0, 1'b1, '0);
        step(1'b1, 1'b1, 8'h9A);
        check("R8 level", 32'(level), 1);
        check("R8 head", 32'(head), 32'h9A);

        // R1: reset mid-run
        step(1'b1, 1'b0, 8'h11);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model.delete();
        rst_n = 1'b1;
        check("R1 level after reset", 32'(level), 0);
        check("R1 empty after reset", 32'(empty), 1);
        check("R1 full after reset", 32'(full), 0);
        report();
    end

endmodule